// File: doc/BRIEF.md
# Shift-Register FIFO with Occupancy Counter

This block is a short synchronous first-in first-out buffer. It stores words in a shift chain instead of a dual-port memory. Each accepted write pushes the new word in at stage 0 and moves every stored word one stage deeper. A single up/down counter tracks how many words the buffer holds. The same counter also picks the chain stage that holds the oldest word, which feeds the read port. The read port is first-word fall-through: whenever the buffer is not empty, `rd_data` already shows the next word to be consumed, and a read strobe consumes it.

A parameter adds a registered output stage, which shortens the path from the tap multiplexer to the pins. When that stage is on, the head word sits in the output register and the chain holds only the words behind it. A write that arrives while the output register is vacant goes straight into the register. As a result, the cycle after a write into an empty buffer shows the word at the port in both modes, and the two modes behave the same at every port on every cycle. A write into a full buffer and a read from an empty buffer are dropped, and each sets its own sticky error flag.

Top module: `shreg_fifo`

## Requirements
- R1: After a synchronous reset, `level` is 0, `empty` is 1, `full` is 0, and both `overflow` and `underflow` are 0.
- R2: Words leave in the order they were accepted. Whenever `empty` is 0, `rd_data` equals the oldest stored word.
- R3: `level` rises by one after a cycle with only an accepted write, and falls by one after a cycle with only an accepted read.
- R4: `full` is 1 exactly when `level` equals DEPTH, and `empty` is 1 exactly when `level` is 0. `level` never exceeds DEPTH.
- R5: A write strobe while `full` is 1 is dropped, and stored contents and `level` do not change because of it. It sets `overflow`, which stays at 1 until reset.
- R6: A read strobe while `empty` is 1 is dropped and `level` stays 0. It sets `underflow`, which stays at 1 until reset.
- R7: When read and write strobes arrive together with `level` between 1 and DEPTH-1, the oldest word is consumed, the new word is appended, and `level` is unchanged.
- R8: After a cycle that writes into an empty buffer, the next cycle shows `empty` at 0 and `rd_data` equal to the written word. This holds in both output modes.
- R9: With OUT_REG set to 1, every port behaves as with OUT_REG set to 0, cycle for cycle, and `level` counts the word held in the output register.
- R10: When read and write strobes arrive together while empty, the read is dropped and sets `underflow`, the write is accepted, and `level` becomes 1.
- R11: When read and write strobes arrive together while full, the write is dropped and sets `overflow`, the read is accepted, and `level` becomes DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_data | input | W | Word to write |
| rd_en | input | 1 | Read strobe; consumes the word on `rd_data` |
| rd_data | output | W | Oldest stored word (fall-through) |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no word |
| level | output | $clog2(DEPTH+1) | Number of stored words |
| overflow | output | 1 | Sticky: a write was dropped while full |
| underflow | output | 1 | Sticky: a read was dropped while empty |

## Verification
The bench drives both output modes side by side and compares them with one queue model on every cycle. The targeted cases are:
- A read together with a write at level 1 in registered mode. If the head refill or the bypass is wrong, the port shows a stale word or goes empty.
- A write into an empty buffer. With no bypass, the word appears one cycle late.
- Paired strobes at both the full and the empty boundary. Admitting both strobes there makes `level` wrap or corrupts the head word.
- A dropped write at full, followed by a complete drain. This exposes a chain that shifted on a dropped write, because the last word read out would then be wrong.

// File: rtl/shreg_fifo_pkg.sv
package shreg_fifo_pkg;

    typedef struct packed {
        logic ovf;
        logic unf;
    } fifo_err_t;

    typedef enum logic [1:0] {
        HEAD_HOLD,
        HEAD_TAP,
        HEAD_BYPASS,
        HEAD_DRAIN
    } head_src_e;

endpackage

// File: rtl/shreg_fifo_store.sv
module shreg_fifo_store #(
    parameter int W        = 8,
    parameter int SR_DEPTH = 16,
    parameter int IW       = 4
) (
    input  logic          clk,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic [IW-1:0] tap_idx,
    output logic [W-1:0]  tap_data
);

    localparam logic [IW:0] TAP_LIMIT = (IW+1)'(SR_DEPTH);

    logic [W-1:0] sr_d [SR_DEPTH];
    logic [W-1:0] sr_q [SR_DEPTH];

    always_comb begin
        sr_d[0] = push ? din : sr_q[0];
        for (int i = 1; i < SR_DEPTH; i++) begin
            sr_d[i] = push ? sr_q[i-1] : sr_q[i];
        end
    end

    always_ff @(posedge clk) begin
        sr_q <= sr_d;
    end

    generate
        if (SR_DEPTH == (1 << IW)) begin : g_tap_full
            assign tap_data = sr_q[tap_idx];
        end else begin : g_tap_guarded
            assign tap_data = ({1'b0, tap_idx} < TAP_LIMIT) ? sr_q[tap_idx] : '0;
        end
    endgenerate

endmodule

// File: rtl/shreg_fifo_ctrl.sv
module shreg_fifo_ctrl
    import shreg_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          wr_acc,
    output logic          rd_acc,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          overflow,
    output logic          underflow
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] cnt;
        fifo_err_t     err;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        full   = (st_q.cnt == FULL_LVL);
        empty  = (st_q.cnt == '0);
        wr_acc = wr_en && !full;
        rd_acc = rd_en && !empty;
        st_d   = st_q;
        if (wr_en && full)  st_d.err.ovf = 1'b1;
        if (rd_en && empty) st_d.err.unf = 1'b1;
        case ({wr_acc, rd_acc})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign level     = st_q.cnt;
    assign overflow  = st_q.err.ovf;
    assign underflow = st_q.err.unf;

    p_level_bound_r4: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= FULL_LVL);
    p_full_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> (full && overflow));
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    p_empty_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> (empty && underflow));
    p_unf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);
    p_pair_keeps_level_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && !full && !empty) |=> $stable(level));

endmodule

// File: rtl/shreg_fifo_head.sv
module shreg_fifo_head
    import shreg_fifo_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 5,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_acc,
    input  logic          rd_acc,
    input  logic [CW-1:0] level,
    input  logic [W-1:0]  din,
    input  logic [W-1:0]  tap_data,
    output logic          push,
    output logic [IW-1:0] tap_idx,
    output logic [W-1:0]  head_data
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] word;
    } head_state_t;

    head_state_t hd_d, hd_q;
    head_src_e   src;
    logic        refill;
    logic        chain_has;
    logic [CW-1:0] lvl_m2;

    always_comb begin
        refill    = !hd_q.vld || rd_acc;
        chain_has = (level >= CW'(2));
        lvl_m2    = level - CW'(2);
        tap_idx   = chain_has ? lvl_m2[IW-1:0] : '0;
        if (!refill)        src = HEAD_HOLD;
        else if (chain_has) src = HEAD_TAP;
        else if (wr_acc)    src = HEAD_BYPASS;
        else                src = HEAD_DRAIN;
        push = wr_acc && (src != HEAD_BYPASS);
        hd_d = hd_q;
        case (src)
            HEAD_TAP:    begin hd_d.vld = 1'b1; hd_d.word = tap_data; end
            HEAD_BYPASS: begin hd_d.vld = 1'b1; hd_d.word = din;      end
            HEAD_DRAIN:  hd_d.vld = 1'b0;
            default:     hd_d = hd_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) hd_q <= '0;
        else     hd_q <= hd_d;
    end

    assign head_data = hd_q.word;

    p_head_tracks_level_r9: assert property (@(posedge clk) disable iff (rst)
        hd_q.vld == (level != '0));
    p_bypass_lands_r8: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && wr_acc) |=> (hd_q.vld && hd_q.word == $past(din)));

endmodule

// File: rtl/shreg_fifo.sv
module shreg_fifo #(
    parameter int W       = 8,
    parameter int DEPTH   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [W-1:0]               wr_data,
    input  logic                       rd_en,
    output logic [W-1:0]               rd_data,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       overflow,
    output logic                       underflow
);

    localparam int CW       = $clog2(DEPTH+1);
    localparam int IW       = $clog2(DEPTH);
    localparam int SR_DEPTH = OUT_REG ? DEPTH - 1 : DEPTH;

    logic          wr_acc, rd_acc;
    logic          push;
    logic [IW-1:0] tap_idx;
    logic [W-1:0]  tap_data;

    shreg_fifo_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_acc    (wr_acc),
        .rd_acc    (rd_acc),
        .level     (level),
        .full      (full),
        .empty     (empty),
        .overflow  (overflow),
        .underflow (underflow)
    );

    shreg_fifo_store #(.W(W), .SR_DEPTH(SR_DEPTH), .IW(IW)) u_store (
        .clk      (clk),
        .push     (push),
        .din      (wr_data),
        .tap_idx  (tap_idx),
        .tap_data (tap_data)
    );

    generate
        if (OUT_REG) begin : g_head_reg
            shreg_fifo_head #(.W(W), .CW(CW), .IW(IW)) u_head (
                .clk       (clk),
                .rst       (rst),
                .wr_acc    (wr_acc),
                .rd_acc    (rd_acc),
                .level     (level),
                .din       (wr_data),
                .tap_data  (tap_data),
                .push      (push),
                .tap_idx   (tap_idx),
                .head_data (rd_data)
            );
        end else begin : g_head_flow
            logic [CW-1:0] lvl_m1;
            assign lvl_m1  = level - CW'(1);
            assign tap_idx = (level == '0) ? '0 : lvl_m1[IW-1:0];
            assign push    = wr_acc;
            assign rd_data = tap_data;
        end
    endgenerate

endmodule

// File: tb/test_shreg_fifo.sv
module test_shreg_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int DEPTH      = 8;
    localparam int CW         = $clog2(DEPTH+1);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;

    logic [W-1:0]  rd_data_r, rd_data_f;
    logic          full_r, full_f, empty_r, empty_f;
    logic [CW-1:0] level_r, level_f;
    logic          ovf_r, ovf_f, unf_r, unf_f;

    int checks = 0;
    int errors = 0;
    int mq[$];
    bit m_ovf = 0;
    bit m_unf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shreg_fifo #(.W(W), .DEPTH(DEPTH), .OUT_REG(1'b1)) i_shreg_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data_r), .full(full_r), .empty(empty_r), .level(level_r),
        .overflow(ovf_r), .underflow(unf_r)
    );

    shreg_fifo #(.W(W), .DEPTH(DEPTH), .OUT_REG(1'b0)) i_shreg_fifo_flow (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data_f), .full(full_f), .empty(empty_f), .level(level_f),
        .overflow(ovf_f), .underflow(unf_f)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        int n = mq.size();
        chk("R9/R3", {req, " level reg"},  int'(level_r), n);
        chk("R3",    {req, " level flow"}, int'(level_f), n);
        chk("R9/R4", {req, " empty reg"},  int'(empty_r), int'(n == 0));
        chk("R4",    {req, " empty flow"}, int'(empty_f), int'(n == 0));
        chk("R9/R4", {req, " full reg"},   int'(full_r),  int'(n == DEPTH));
        chk("R4",    {req, " full flow"},  int'(full_f),  int'(n == DEPTH));
        chk("R9/R5", {req, " overflow reg"},   int'(ovf_r), int'(m_ovf));
        chk("R5",    {req, " overflow flow"},  int'(ovf_f), int'(m_ovf));
        chk("R9/R6", {req, " underflow reg"},  int'(unf_r), int'(m_unf));
        chk("R6",    {req, " underflow flow"}, int'(unf_f), int'(m_unf));
        if (n > 0) begin
            chk("R9/R2", {req, " head reg"},  int'(rd_data_r), mq[0]);
            chk("R2",    {req, " head flow"}, int'(rd_data_f), mq[0]);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic step(bit w, logic [W-1:0] d, bit r, string req);
        bit wa, ra;
        wr_en = w; wr_data = d; rd_en = r;
        wa = w && (mq.size() < DEPTH);
        ra = r && (mq.size() > 0);
        if (w && !wa) m_ovf = 1;
        if (r && !ra) m_unf = 1;
        if (ra) void'(mq.pop_front());
        if (wa) mq.push_back(int'(d));
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        compare_all(req);
    endtask

    task automatic do_reset();
        rst = 1;
        mq.delete();
        m_ovf = 0; m_unf = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        chk("R1", "level reg",  int'(level_r), 0);
        chk("R1", "level flow", int'(level_f), 0);
        chk("R1", "empty reg",  int'(empty_r), 1);
        chk("R1", "empty flow", int'(empty_f), 1);
        chk("R1", "full reg",   int'(full_r), 0);
        chk("R1", "full flow",  int'(full_f), 0);
        chk("R1", "errors reg", int'({ovf_r, unf_r}), 0);
        chk("R1", "errors flow", int'({ovf_f, unf_f}), 0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        step(0, 8'h00, 1, "R6 read-empty");
        step(1, 8'hA5, 0, "R8 write-into-empty");
        chk("R8", "head reg after first write", int'(rd_data_r), 8'hA5);
        for (int i = 1; i < DEPTH; i++) step(1, W'(8'h10 + i), 0, "R4 fill");
        step(1, 8'hEE, 0, "R5 write-when-full");
        step(1, 8'hEF, 1, "R11 pair-at-full");
        for (int i = 0; i < 4; i++) step(1, W'(8'h40 + i), 1, "R7 pair-mid");
        while (mq.size() > 0) step(0, 8'h00, 1, "R2 drain");
        step(1, 8'h5A, 1, "R10 pair-at-empty");
        step(1, 8'h77, 1, "R7 pair-at-level-1");
        step(1, 8'h78, 1, "R7 pair-at-level-1 again");
        step(0, 8'h00, 1, "R2 last word");

        do_reset();
        for (int k = 0; k < 3000; k++) begin
            int phase = (k / 40) % 3;
            int pw = (phase == 0) ? 80 : (phase == 1) ? 25 : 50;
            int pr = (phase == 0) ? 25 : (phase == 1) ? 80 : 50;
            step(($urandom % 100) < pw, W'($urandom), ($urandom % 100) < pr, "R2 random");
        end
        do_reset();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule